// File: doc/BRIEF.md
# Serial Receive Idle-Gap Timeout

This block sits beside an asynchronous serial receiver and measures the quiet time on the line after each character has been fully received. Each completed character restarts a count of bit periods. If the count reaches a limit set by software before another character arrives, the block decides that the message has ended.

At that point two things happen in the same clock cycle. A sticky end-of-message interrupt flag is raised, and a one-cycle pulse goes to the receive DMA engine. That pulse makes the engine close its current transfer early, so the bytes already collected can be passed on without waiting for a full buffer.

After a timeout the timer stays disarmed until the next character arrives, so a line that stays silent for a long time gives one interrupt, not a series. Software clears the flag by writing a one to the acknowledge input. A limit of zero turns the whole function off.

Top module: `rx_idle_timeout`

## Requirements
- R1: While reset is high and in the cycle after it, `idle_irq` and `dma_stop` are both low.
- R2: The limit is counted in cycles with `bit_tick` high. With `idle_limit` = L (L >= 1), the timeout fires on the L-th tick that follows a `frame_done` strobe, and never on an earlier tick. Cycles without a tick do not count. The outputs change on the clock edge that samples that tick.
- R3: `dma_stop` is high for exactly one cycle for each timeout. It is high in the cycle where `idle_irq` goes from 0 to 1, and `idle_irq` never rises without it.
- R4: After a timeout, further ticks give no new timeout until another `frame_done` arrives.
- R5: A `frame_done` strobe that comes before the limit is reached clears the count. A full L further ticks are then needed.
- R6: When `idle_limit` is 0, no timeout fires, however many ticks arrive.
- R7: `idle_irq` stays high until a cycle with `irq_ack` = 1. It is low after that edge unless a new timeout fires in the same cycle.
- R8: If `irq_ack` and a timeout fall in the same cycle, `idle_irq` stays high.
- R9: When `frame_done` and `bit_tick` are high in the same cycle, the frame wins. The timer restarts and that tick is not counted.
- R10: After reset, ticks alone do not arm the timer. No timeout can fire before the first `frame_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_done | input | 1 | One-cycle strobe: a character frame has been fully received |
| bit_tick | input | 1 | One-cycle strobe, once per bit period |
| idle_limit | input | LIMIT_W | Idle threshold in bit periods; 0 turns the function off |
| irq_ack | input | 1 | Write-one-to-clear for the interrupt flag |
| idle_irq | output | 1 | Sticky end-of-message interrupt flag |
| dma_stop | output | 1 | One-cycle request to end the current receive DMA transfer |

## Verification
The bench sweeps the limit from 1 to 6 and checks the outputs after every tick. A design that is off by one tick would fire one tick early or one tick late. Cycles without a tick are placed between ticks, so a design that counted clock cycles instead of ticks would fire too early. The bench also covers:
- ticks that continue after a timeout, where a design that re-arms would produce repeated pulses;
- a frame arriving partway through a count, where a design that fails to restart would fire early;
- a limit of zero;
- an acknowledge in the same cycle as a new timeout, where a design with the wrong priority would lose the interrupt;
- a frame and a tick in the same cycle, where a design that counts that tick would fire one tick early.

// File: rtl/rxto_pkg.sv
package rxto_pkg;

    localparam int DEF_LIMIT_W = 16;

    typedef enum logic {
        TMR_DISARMED = 1'b0,
        TMR_COUNTING = 1'b1
    } tmr_state_e;

    typedef struct packed {
        logic restart;
        logic tick;
    } rx_evt_t;

    function automatic rx_evt_t decode_evt(input logic frame, input logic tick);
        rx_evt_t e;
        e.restart = frame;
        e.tick    = tick & ~frame;
        return e;
    endfunction

endpackage

// File: rtl/rxto_idle_timer.sv
module rxto_idle_timer
    import rxto_pkg::*;
#(
    parameter int LIMIT_W = DEF_LIMIT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  rx_evt_t            evt,
    input  logic [LIMIT_W-1:0] limit,
    output logic               expire
);
    localparam logic [LIMIT_W-1:0] CNT_MAX = {LIMIT_W{1'b1}};

    tmr_state_e         state_q;
    logic [LIMIT_W-1:0] cnt_q;
    logic [LIMIT_W:0]   next_cnt;
    logic               limit_on;
    logic               reached;

    always_comb begin
        next_cnt = {1'b0, cnt_q} + {{LIMIT_W{1'b0}}, 1'b1};
        limit_on = (limit != '0);
        reached  = limit_on && (next_cnt >= {1'b0, limit});
        expire   = (state_q == TMR_COUNTING) && evt.tick && reached;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TMR_DISARMED;
            cnt_q   <= '0;
        end else if (evt.restart) begin
            state_q <= TMR_COUNTING;
            cnt_q   <= '0;
        end else if (state_q == TMR_COUNTING && evt.tick) begin
            if (reached) begin
                state_q <= TMR_DISARMED;
                cnt_q   <= '0;
            end else if (cnt_q != CNT_MAX) begin
                cnt_q   <= next_cnt[LIMIT_W-1:0];
            end
        end
    end

endmodule

// File: rtl/rxto_irq_reg.sv
module rxto_irq_reg (
    input  logic clk,
    input  logic rst,
    input  logic expire,
    input  logic ack,
    output logic flag,
    output logic pulse
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag  <= 1'b0;
            pulse <= 1'b0;
        end else begin
            flag  <= (flag & ~ack) | expire;
            pulse <= expire;
        end
    end
endmodule

// File: rtl/rx_idle_timeout.sv
module rx_idle_timeout
    import rxto_pkg::*;
#(
    parameter int LIMIT_W = DEF_LIMIT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_done,
    input  logic               bit_tick,
    input  logic [LIMIT_W-1:0] idle_limit,
    input  logic               irq_ack,
    output logic               idle_irq,
    output logic               dma_stop
);
    rx_evt_t evt;
    logic    expire;

    assign evt = decode_evt(frame_done, bit_tick);

    rxto_idle_timer #(.LIMIT_W(LIMIT_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .limit  (idle_limit),
        .expire (expire)
    );

    rxto_irq_reg u_irq (
        .clk    (clk),
        .rst    (rst),
        .expire (expire),
        .ack    (irq_ack),
        .flag   (idle_irq),
        .pulse  (dma_stop)
    );
endmodule

// File: rtl/rxto_checker.sv
module rxto_checker #(
    parameter int LIMIT_W = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               frame_done,
    input logic               bit_tick,
    input logic [LIMIT_W-1:0] idle_limit,
    input logic               irq_ack,
    input logic               idle_irq,
    input logic               dma_stop
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!idle_irq && !dma_stop));

    assert_pulse_with_flag_R3: assert property (@(posedge clk) disable iff (rst)
        dma_stop |-> idle_irq);

    assert_pulse_single_R3: assert property (@(posedge clk) disable iff (rst)
        dma_stop |=> !dma_stop);

    assert_rise_has_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(idle_irq) |-> dma_stop);

    assert_zero_limit_off_R6: assert property (@(posedge clk) disable iff (rst)
        (idle_limit == '0) |=> !dma_stop);

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (idle_irq && !irq_ack) |=> idle_irq);

    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !bit_tick) |=> !idle_irq);

    assert_frame_wins_R9: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !dma_stop);
endmodule

bind rx_idle_timeout rxto_checker #(.LIMIT_W(LIMIT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .frame_done (frame_done),
    .bit_tick   (bit_tick),
    .idle_limit (idle_limit),
    .irq_ack    (irq_ack),
    .idle_irq   (idle_irq),
    .dma_stop   (dma_stop)
);

// File: tb/sim_rx_idle_timeout.sv
module sim_rx_idle_timeout;
    localparam int CLK_PERIOD = 10;
    localparam int LW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          frame_done = 1'b0;
    logic          bit_tick = 1'b0;
    logic [LW-1:0] idle_limit = '0;
    logic          irq_ack = 1'b0;
    logic          idle_irq;
    logic          dma_stop;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_idle_timeout #(.LIMIT_W(LW)) u0 (
        .clk(clk), .rst(rst), .frame_done(frame_done), .bit_tick(bit_tick),
        .idle_limit(idle_limit), .irq_ack(irq_ack),
        .idle_irq(idle_irq), .dma_stop(dma_stop)
    );

    task automatic cyc(input logic f, input logic t, input logic a);
        @(negedge clk);
        frame_done = f; bit_tick = t; irq_ack = a;
        @(posedge clk);
        #1;
        frame_done = 1'b0; bit_tick = 1'b0; irq_ack = 1'b0;
    endtask

    task automatic check(input string tag, input logic exp_irq, input logic exp_dma);
        checks++;
        if (idle_irq !== exp_irq || dma_stop !== exp_dma) begin
            fails++;
            $display("FAIL %s: irq/dma actual %b/%b expected %b/%b at %0t",
                     tag, idle_irq, dma_stop, exp_irq, exp_dma, $time);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) cyc(0, 1, 0);
        check("R1", 0, 0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        check("R1", 0, 0);

        // R10: ticks without any frame never fire
        idle_limit = 3;
        for (int i = 0; i < 8; i++) begin
            cyc(0, 1, 0);
            check("R10", 0, 0);
        end

        // R2/R3/R4/R7: sweep limits, idle gaps between ticks
        for (int L = 1; L <= 6; L++) begin
            idle_limit = LW'(L);
            cyc(0, 0, 1);
            cyc(1, 0, 0);
            check("R2", 0, 0);
            for (int k = 1; k <= L + 3; k++) begin
                cyc(0, 0, 0);
                check(k - 1 >= L ? "R7" : "R2", (k - 1 >= L), 0);
                cyc(0, 1, 0);
                if (k < L)       check("R2", 0, 0);
                else if (k == L) check("R3", 1, 1);
                else             check("R4", 1, 0);
            end
            cyc(0, 0, 1);
            check("R7", 0, 0);
        end

        // R5: a frame mid-count restarts
        idle_limit = 4;
        cyc(1, 0, 0);
        repeat (3) begin cyc(0, 1, 0); check("R5", 0, 0); end
        cyc(1, 0, 0);
        repeat (3) begin cyc(0, 1, 0); check("R5", 0, 0); end
        cyc(0, 1, 0);
        check("R5", 1, 1);
        cyc(0, 0, 1);
        check("R7", 0, 0);

        // R6: zero limit disables
        idle_limit = 0;
        cyc(1, 0, 0);
        for (int i = 0; i < 20; i++) begin
            cyc(0, 1, 0);
            check("R6", 0, 0);
        end

        // R8: ack and a new timeout in the same cycle
        idle_limit = 1;
        cyc(1, 0, 0);
        cyc(0, 1, 0);
        check("R8", 1, 1);
        cyc(1, 0, 0);
        check("R8", 1, 0);
        cyc(0, 1, 1);
        check("R8", 1, 1);
        cyc(0, 0, 1);
        check("R7", 0, 0);

        // R9: frame and tick together, the tick is not counted
        idle_limit = 2;
        cyc(1, 0, 0);
        cyc(0, 1, 0);
        check("R9", 0, 0);
        cyc(1, 1, 0);
        check("R9", 0, 0);
        cyc(0, 1, 0);
        check("R9", 0, 0);
        cyc(0, 1, 0);
        check("R9", 1, 1);
        cyc(0, 0, 1);
        check("R7", 0, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule